// File: doc/BRIEF.md
# Board System-Controller Register Slave

This block is a 32-bit register slave for the system controller of a development board. A processor reaches it through a simple bus that completes each transfer in one cycle. The bus supplies a 20-bit offset, a read strobe, a write strobe and write data. Through this bus the processor does the following:

- drives an eight-LED bar;
- loads an eight-character text display, one character at a time or all eight at once as hexadecimal text;
- requests a board reset by writing a key value;
- keeps a break byte and a general-purpose output byte.

The block also carries bit-bang I2C registers for output enable, line levels, select and input. A serial EEPROM model sits behind the clock and data levels. The EEPROM model updates on every write to the line-level register. Its data-line output appears as bit 0 of the I2C input register, so software can run a bus transaction by toggling bits.

Writes take effect at the clock edge on which the write strobe is sampled. Read data is registered. It is valid in the cycle after the read strobe and is zero in any cycle that follows no read. The reset request is a one-cycle pulse in the cycle after the matching write.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset the outputs are: LEDs 0x00, text all spaces (0x20 in every byte), reset request low, clock level 1, data level 1, output enable 0. The registers then read: break 0x0A, select 1, line levels 0x3, I2C input 0x3.
- R2: An offset that maps to no register reads 0x00000000, and a write to it changes no output or register. Read data is zero in any cycle that does not follow a read strobe.
- R3: The switch register (0x200) and the jumper register (0x210) read 0 even after a write. The status register (0x208) reads 0x12 when the byte-order parameter selects big-endian and 0x10 otherwise (default).
- R4: The LED register (0x408) keeps write bits [7:0] and drives them on the LED output, where bit i lit means LED i is on. It reads back the kept byte with upper bits 0, and the LEDs hold their value between writes.
- R5: Character register k (k = 0..7) at offset 0x418 + 8k stores write bits [7:0] into text byte k, which is output bits [8k+7:8k]. The other characters are unchanged.
- R6: A write to the hex-word register (0x410) sets text byte k to the uppercase ASCII hexadecimal digit of value bits [31-4k:28-4k]. Byte 0 therefore holds the most significant nibble.
- R7: A write of exactly 0x00000042 to offset 0x500 raises the reset request for one cycle. Any other value at that offset, including one whose low byte is 0x42, raises nothing.
- R8: The break register (0x508) and the general-purpose output register (0xA00) each keep write bits [7:0]. The general-purpose byte is also driven on an output.
- R9: The output-enable register (0xB08) keeps bits [1:0] and the select register (0xB18) keeps bit 0. The line-level register (0xB10) keeps all 32 bits, drives the clock level from bit 1 and the data level from bit 0, and reads back the whole word.
- R10: The general-purpose input register (0xA08) reads the line-level register when select is 1 and reads 0 when select is 0.
- R11: The I2C input register (0xB00) reads binary 1 in bits [31:1] and the EEPROM's data-line output in bit 0. The EEPROM works as follows. A fall of the data level while the clock level stays 1 starts a transfer. It then takes 8 bits, one on each rise of the clock level. On the next rise of the clock level after those 8 bits, it pulls its data output to 0 as an acknowledge. The same happens after the following 8 address bits. When it is idle or not acknowledging, its data output follows the last written data level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_off | input | 20 | Decoded register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the read strobe |
| led_o | output | 8 | LED bar, 1 = lit |
| gp_o | output | 8 | General-purpose output byte |
| text_o | output | 64 | Eight display characters, byte k = character k |
| reset_req_o | output | 1 | One-cycle board reset request |
| i2c_scl_o | output | 1 | Clock line level |
| i2c_sda_o | output | 1 | Data line level |
| i2c_oe_o | output | 2 | I2C output enables |

## Verification
Some rules are checked by assertions on every cycle:

- the LEDs and the text bytes hold unless a write strobe arrives;
- read data drops to zero after a cycle with no read;
- a reset pulse only ever follows a write;
- the EEPROM's data output holds between line-level writes and is forced low by an acknowledging clock rise.

Other behaviour can only be shown by the bench's scenarios: the exact key match for reset, the hexadecimal digit order, the byte masks, the select-controlled loopback, and the acknowledge placement after a whole start, command and address sequence.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

  localparam int OFF_W   = 20;
  localparam int DATA_W  = 32;
  localparam int NCHARS  = 8;
  localparam int EE_AW   = 8;

  typedef logic [OFF_W-1:0] off_t;

  localparam off_t OFF_SWITCH   = 20'h00200;
  localparam off_t OFF_STATUS   = 20'h00208;
  localparam off_t OFF_JUMPER   = 20'h00210;
  localparam off_t OFF_LED      = 20'h00408;
  localparam off_t OFF_HEXWORD  = 20'h00410;
  localparam off_t OFF_CHAR0    = 20'h00418;
  localparam off_t OFF_SOFTRST  = 20'h00500;
  localparam off_t OFF_BRK      = 20'h00508;
  localparam off_t OFF_GPOUT    = 20'h00A00;
  localparam off_t OFF_GPIN     = 20'h00A08;
  localparam off_t OFF_I2C_IN   = 20'h00B00;
  localparam off_t OFF_I2C_OE   = 20'h00B08;
  localparam off_t OFF_I2C_OUT  = 20'h00B10;
  localparam off_t OFF_I2C_SEL  = 20'h00B18;

  localparam logic [DATA_W-1:0] SOFTRST_KEY = 32'h0000_0042;
  localparam logic [DATA_W-1:0] I2C_IN_INIT = 32'h0000_0003;

  // One nibble to its uppercase ASCII hex digit.
  function automatic logic [7:0] nibble_to_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'b0, n}) : (8'h37 + {4'b0, n});
  endfunction

  // EEPROM contents are computed, not stored.
  function automatic logic [7:0] eeprom_byte(input logic [EE_AW-1:0] a);
    return {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction

endpackage

// File: rtl/bctl_i2c_eeprom.sv
module bctl_i2c_eeprom
  import board_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out
);

  localparam logic [4:0] TICK_CMD_END  = 5'd9;
  localparam logic [4:0] TICK_ADDR_END = 5'd17;

  logic [4:0]       tick_q, tick_n;
  logic             rw_q, rw_n;
  logic [EE_AW-1:0] addr_q, addr_n;
  logic [7:0]       data_q, data_n;
  logic             ack_q, ack_n;
  logic             scl_q, scl_n;
  logic             sda_q, sda_n;
  logic             line_sda;

  // Named events for the checks below
  logic scl_rise_evt;
  logic start_evt;
  assign scl_rise_evt = we && !scl_q && scl_in;
  assign start_evt    = we && scl_q && scl_in && sda_q && !sda_in;

  always_comb begin
    tick_n   = tick_q;
    rw_n     = rw_q;
    addr_n   = addr_q;
    data_n   = data_q;
    ack_n    = ack_q;
    scl_n    = scl_q;
    sda_n    = sda_q;
    line_sda = sda_in;
    if (we) begin
      if (scl_q && scl_in && (sda_q != sda_in)) begin
        if (!sda_in) begin
          tick_n = 5'd1;
          rw_n   = 1'b0;
        end
      end else if (tick_q == 5'd0 && !ack_q) begin
        line_sda = sda_in;
      end else if (!scl_q && scl_in) begin
        if (ack_q) begin
          line_sda = 1'b0;
          ack_n    = 1'b0;
        end else if (sda_q == sda_in) begin
          if (tick_q < TICK_CMD_END) begin
            rw_n   = sda_in;
            tick_n = tick_q + 5'd1;
            if (tick_q == TICK_CMD_END - 5'd1) ack_n = 1'b1;
          end else if (tick_q < TICK_ADDR_END) begin
            if (rw_q) line_sda = data_q[7];
            addr_n = {addr_q[EE_AW-2:0], sda_in};
            tick_n = tick_q + 5'd1;
            data_n = {data_q[6:0], 1'b0};
            if (tick_q == TICK_ADDR_END - 5'd1) begin
              data_n = eeprom_byte(addr_n);
              ack_n  = 1'b1;
              tick_n = 5'd0;
            end
          end else begin
            line_sda = 1'b0;
          end
        end
      end
      scl_n = scl_in;
      sda_n = line_sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      rw_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      ack_q  <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      tick_q <= tick_n;
      rw_q   <= rw_n;
      addr_q <= addr_n;
      data_q <= data_n;
      ack_q  <= ack_n;
      scl_q  <= scl_n;
      sda_q  <= sda_n;
    end
  end

  assign sda_out = sda_q;

  // R11: an acknowledging clock rise pulls the data output low
  p_ack_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise_evt && ack_q) |=> (sda_out == 1'b0));

  // R11: the line state holds between writes
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(sda_out) && $stable(tick_q)));

  // R11: a start always restarts the bit count
  p_start_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (tick_q == 5'd1));

endmodule

// File: rtl/bctl_display.sv
module bctl_display
  import board_ctrl_pkg::*;
#(
  parameter int N = NCHARS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   char_we,
  input  logic [7:0]     char_byte,
  input  logic           word_we,
  input  logic [4*N-1:0] word,
  output logic [8*N-1:0] text
);

  localparam logic [7:0] BLANK = 8'h20;

  // A character write wins over a word write in the same cycle.
  for (genvar k = 0; k < N; k++) begin : g_char
    logic [7:0] ch_q;
    logic [3:0] nib;
    assign nib = word[4*(N-1-k) +: 4];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ch_q <= BLANK;
      else if (char_we[k]) ch_q <= char_byte;
      else if (word_we)    ch_q <= nibble_to_ascii(nib);
    end
    assign text[8*k +: 8] = ch_q;
  end

  // R5, R6: text changes only on a display write
  p_text_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|char_we) && !word_we) |=> $stable(text));

  // R5: at most one character register is addressed at a time
  p_char_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(char_we));

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [7:0]        led_o,
  output logic [7:0]        gp_o,
  output logic [8*NCHARS-1:0] text_o,
  output logic              reset_req_o,
  output logic              i2c_scl_o,
  output logic              i2c_sda_o,
  output logic [1:0]        i2c_oe_o
);

  localparam logic [DATA_W-1:0] STATUS_VAL = BIG_ENDIAN ? 32'h12 : 32'h10;

  logic [7:0]        led_q, brk_q, gp_q;
  logic [1:0]        oe_q;
  logic [DATA_W-1:0] i2c_out_q;
  logic              sel_q;
  logic              rst_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              ee_sda;

  // Named write events
  logic wr_led, wr_brk, wr_gp, wr_oe, wr_i2c, wr_sel, wr_hex, key_hit;
  logic [NCHARS-1:0] wr_char;

  assign wr_led  = bus_wr && (bus_off == OFF_LED);
  assign wr_brk  = bus_wr && (bus_off == OFF_BRK);
  assign wr_gp   = bus_wr && (bus_off == OFF_GPOUT);
  assign wr_oe   = bus_wr && (bus_off == OFF_I2C_OE);
  assign wr_i2c  = bus_wr && (bus_off == OFF_I2C_OUT);
  assign wr_sel  = bus_wr && (bus_off == OFF_I2C_SEL);
  assign wr_hex  = bus_wr && (bus_off == OFF_HEXWORD);
  assign key_hit = bus_wr && (bus_off == OFF_SOFTRST) && (bus_wdata == SOFTRST_KEY);

  for (genvar k = 0; k < NCHARS; k++) begin : g_cdec
    assign wr_char[k] = bus_wr && (bus_off == off_t'(OFF_CHAR0 + 20'(8 * k)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q     <= 8'h00;
      brk_q     <= 8'h0A;
      gp_q      <= 8'h00;
      oe_q      <= 2'b00;
      i2c_out_q <= 32'h3;
      sel_q     <= 1'b1;
      rst_q     <= 1'b0;
    end else begin
      if (wr_led) led_q     <= bus_wdata[7:0];
      if (wr_brk) brk_q     <= bus_wdata[7:0];
      if (wr_gp)  gp_q      <= bus_wdata[7:0];
      if (wr_oe)  oe_q      <= bus_wdata[1:0];
      if (wr_i2c) i2c_out_q <= bus_wdata;
      if (wr_sel) sel_q     <= bus_wdata[0];
      rst_q <= key_hit;
    end
  end

  bctl_display #(.N(NCHARS)) u_display (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_we   (wr_char),
    .char_byte (bus_wdata[7:0]),
    .word_we   (wr_hex),
    .word      (bus_wdata),
    .text      (text_o)
  );

  bctl_i2c_eeprom u_eeprom (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_i2c),
    .scl_in  (bus_wdata[1]),
    .sda_in  (bus_wdata[0]),
    .sda_out (ee_sda)
  );

  always_comb begin
    case (bus_off)
      OFF_SWITCH,
      OFF_JUMPER:  rd_mux = '0;
      OFF_STATUS:  rd_mux = STATUS_VAL;
      OFF_LED:     rd_mux = {24'b0, led_q};
      OFF_BRK:     rd_mux = {24'b0, brk_q};
      OFF_GPOUT:   rd_mux = {24'b0, gp_q};
      OFF_GPIN:    rd_mux = sel_q ? i2c_out_q : '0;
      OFF_I2C_IN:  rd_mux = {I2C_IN_INIT[DATA_W-1:1], ee_sda};
      OFF_I2C_OE:  rd_mux = {30'b0, oe_q};
      OFF_I2C_OUT: rd_mux = i2c_out_q;
      OFF_I2C_SEL: rd_mux = {31'b0, sel_q};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
    else             rdata_q <= '0;
  end

  assign bus_rdata   = rdata_q;
  assign led_o       = led_q;
  assign gp_o        = gp_q;
  assign reset_req_o = rst_q;
  assign i2c_scl_o   = i2c_out_q[1];
  assign i2c_sda_o   = i2c_out_q[0];
  assign i2c_oe_o    = oe_q;

  // R7: a reset pulse only follows a write cycle
  p_rst_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> $past(bus_wr));

  // R4: LEDs hold without a write
  p_led_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(led_o));

  // R2: read data is zero after a cycle without a read
  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

  // R9: line levels change only on a write
  p_lines_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(i2c_scl_o) && $stable(i2c_sda_o)));

endmodule

// File: tb/board_ctrl_regs_tb.sv
module board_ctrl_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] bus_off = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  led_o, gp_o;
  logic [63:0] text_o;
  logic        reset_req_o, i2c_scl_o, i2c_sda_o;
  logic [1:0]  i2c_oe_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #5 clk = ~clk;

  board_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .led_o(led_o), .gp_o(gp_o), .text_o(text_o), .reset_req_o(reset_req_o),
    .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o), .i2c_oe_o(i2c_oe_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops an expected value for each completed read
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {32'b0, bus_rdata}, {32'b0, e});
    end
  end

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    bus_off = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, input logic [31:0] e, input string t);
    bus_off = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic i2c(input bit scl, input bit sda);
    wr(20'hB10, {30'b0, scl, sda});
  endtask

  function automatic logic [63:0] hex_text(input logic [31:0] v);
    string digits = "0123456789ABCDEF";
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      int nib = (v >> (28 - 4 * k)) & 32'hF;
      r[8*k +: 8] = digits[nib];
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] cmd_bits;
    logic [63:0] txt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 leds", {56'b0, led_o}, 64'h0);
    check("R1 text", text_o, 64'h2020202020202020);
    check("R1 rstreq", {63'b0, reset_req_o}, 64'h0);
    check("R1 lines", {61'b0, i2c_oe_o, i2c_scl_o & i2c_sda_o}, 64'h1);
    rd(20'h508, 32'h0A, "R1 break");
    rd(20'hB18, 32'h1, "R1 select");
    rd(20'hB10, 32'h3, "R1 levels");
    rd(20'hB00, 32'h3, "R1 i2c in");

    // R2: unmapped offsets and idle read data
    wr(20'h00404, 32'hFFFF_FFFF);
    wr(20'hFFFF8, 32'h1234_5678);
    check("R2 unmapped write leds", {56'b0, led_o}, 64'h0);
    check("R2 unmapped write text", text_o, 64'h2020202020202020);
    rd(20'h00404, 32'h0, "R2 unmapped read");
    rd(20'h00410, 32'h0, "R2 hexword read");
    check("R2 idle rdata", {32'b0, bus_rdata}, 64'h0);

    // R3: fixed registers
    wr(20'h200, 32'hFF); wr(20'h210, 32'hFF);
    rd(20'h200, 32'h0, "R3 switch");
    rd(20'h210, 32'h0, "R3 jumper");
    rd(20'h208, 32'h10, "R3 status");

    // R4: LED bar
    wr(20'h408, 32'hABCD_E15A);
    check("R4 led out", {56'b0, led_o}, 64'h5A);
    rd(20'h408, 32'h5A, "R4 led read");
    @(negedge clk);
    check("R4 led hold", {56'b0, led_o}, 64'h5A);

    // R6: hex word
    wr(20'h410, 32'h1234_ABCD);
    check("R6 hex 1234ABCD", text_o, hex_text(32'h1234_ABCD));
    wr(20'h410, 32'hF09E_0A5F);
    check("R6 hex F09E0A5F", text_o, hex_text(32'hF09E_0A5F));

    // R5: single characters
    txt = hex_text(32'hF09E_0A5F);
    wr(20'h418, 32'hFFFF_FF41); txt[7:0] = 8'h41;
    wr(20'h450, 32'h7A);        txt[63:56] = 8'h7A;
    wr(20'h430, 32'h2D);        txt[31:24] = 8'h2D;
    check("R5 chars", text_o, txt);
    wr(20'h41C, 32'h55);
    check("R5 misaligned offset", text_o, txt);

    // R7: reset key
    wr(20'h500, 32'h42);
    check("R7 key pulse", {63'b0, reset_req_o}, 64'h1);
    @(negedge clk);
    check("R7 one cycle", {63'b0, reset_req_o}, 64'h0);
    wr(20'h500, 32'h142);
    check("R7 wide value", {63'b0, reset_req_o}, 64'h0);
    wr(20'h500, 32'h43);
    check("R7 other value", {63'b0, reset_req_o}, 64'h0);

    // R8: break and gp output masks
    wr(20'h508, 32'h1234_56C3);
    wr(20'hA00, 32'hFFFF_FF96);
    rd(20'h508, 32'hC3, "R8 break");
    rd(20'hA00, 32'h96, "R8 gp read");
    check("R8 gp out", {56'b0, gp_o}, 64'h96);

    // R9: output enable, select, levels
    wr(20'hB08, 32'hFFFF_FFFE);
    check("R9 oe out", {62'b0, i2c_oe_o}, 64'h2);
    rd(20'hB08, 32'h2, "R9 oe read");
    wr(20'hB18, 32'hFFFF_FFFE);
    rd(20'hB18, 32'h0, "R9 select read");

    // R10: loopback with select 0 then 1
    rd(20'hA08, 32'h0, "R10 loopback off");
    wr(20'hB18, 32'h1);
    rd(20'hA08, 32'h3, "R10 loopback on");

    // R9 + R11: a full sequence from reset levels; start by dropping data
    wr(20'hB10, 32'hCAFE_0002);
    check("R9 scl/sda out", {62'b0, i2c_scl_o, i2c_sda_o}, 64'h2);
    rd(20'hB10, 32'hCAFE_0002, "R9 level read");
    rd(20'hA08, 32'hCAFE_0002, "R10 loopback word");
    rd(20'hB00, 32'h2, "R11 start");
    cmd_bits = 8'hA0;
    for (int b = 7; b >= 0; b--) begin
      i2c(1'b0, cmd_bits[b]);
      i2c(1'b1, cmd_bits[b]);
    end
    i2c(1'b0, 1'b1);
    rd(20'hB00, 32'h3, "R11 before cmd ack");
    i2c(1'b1, 1'b1);
    rd(20'hB00, 32'h2, "R11 cmd ack low");
    cmd_bits = 8'h05;
    for (int b = 7; b >= 0; b--) begin
      i2c(1'b0, cmd_bits[b]);
      i2c(1'b1, cmd_bits[b]);
    end
    i2c(1'b0, 1'b1);
    i2c(1'b1, 1'b1);
    rd(20'hB00, 32'h2, "R11 addr ack low");
    i2c(1'b0, 1'b1);
    rd(20'hB00, 32'h3, "R11 idle follows");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", {63'b0, exp_q.size() == 0}, 64'h1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule